// File: doc/BRIEF.md
# Gate Control List Indirect Programming Port

This block holds the configuration that a time-aware traffic scheduler reads: a 64-bit base time, a 64-bit cycle time, a 32-bit time extension, a 32-bit list length and a 16-entry list of 32-bit gate control words. None of these values can be written directly. Software first writes the value into a staging data register. It then writes a staging control register that holds a target index, a target-select bit and a start bit. Setting the start bit commits the staged value. The start bit reads back as 1 while the commit is in progress and clears itself when the commit is done. Software polls it until it reads 0.

A separate scheduler control register carries the scheduling enable, a list-switch request and a 9-bit time-offset field. The parameters and list are stored twice, as an active bank and a shadow bank. While scheduling is disabled, commits land in the active bank and take effect at once. While scheduling is enabled, commits go to the shadow bank. A switch request then exchanges the two banks in one step, so the scheduler never sees a half-written list. The active bank drives the outputs.

Top module: `gcl_prog_port`

## Requirements
- R1: After a synchronous active-low reset, every register, every bank entry, every output and the read data are zero.
- R2: A read sampled on a clock edge shows its data on `bus_rdata` from that edge on, and the value holds until the next read. The staging data register (byte offset 0x1084) reads back the last value accepted into it. The staging control register (0x1080) reads back index in bits 15:8, select in bit 2 and start in bit 0. Unmapped offsets read zero.
- R3: Writing the staging control register with bit 0 set starts a commit. Bit 0 then reads 1 for exactly two cycles and is 0 from the third edge on. The staged data is stored on the edge that clears it.
- R4: A write to the staging control register with bit 0 clear only records the index and select fields. Nothing is committed.
- R5: While bit 0 of the staging control register is 1, writes to the staging data and staging control registers are ignored.
- R6: With select (bit 2) equal to 1, indices 0 to 5 store, in that order, base time bits 31:0, base time bits 63:32, cycle time bits 31:0, cycle time bits 63:32, time extension and list length. A larger index stores nothing.
- R7: With select equal to 0, the index picks the list entry; entry e drives `gate_list_o[32*e+31:32*e]`. An index of 16 or more stores nothing, and the start bit still clears on time.
- R8: The scheduler control register (0x1050) holds the enable in bit 0, the switch request in bit 1 and the time offset in bits 31:23. The enable and offset drive `sched_en_o` and `time_offset_o`. All three fields read back in the same positions.
- R9: While the enable is 1, commits go to the shadow bank and the outputs do not change.
- R10: When a switch request is set, the next edge exchanges the active and shadow banks. The edge after that clears the request. A write to bit 1 on that clearing edge is ignored.
- R11: While the enable is 0, commits go to the active bank and appear on the outputs on the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| sched_en_o | output | 1 | Scheduling enable |
| time_offset_o | output | 9 | Time-offset field |
| base_time_o | output | 64 | Active base time |
| cycle_time_o | output | 64 | Active cycle time |
| time_ext_o | output | 32 | Active time extension |
| list_len_o | output | 32 | Active list length |
| gate_list_o | output | 512 | Active list entries, entry 0 in the low word |

## Verification
The hardest case to reach is a commit while scheduling is enabled, followed by a bank exchange. Between the two, the outputs must not move, and afterwards they must show exactly the shadow contents. The stimulus enables scheduling and programs a new list length and entry 0 into the shadow bank. It then raises the switch request and reads the control register on consecutive cycles, so that the two-cycle life of the request and the moment of the exchange line up with the output comparison. Writes are also placed inside the two busy cycles right after a start, to show that they are dropped.

// File: rtl/gcl_pkg.sv
// Package: shared offsets, field positions and parameter-index encoding for
// the gate control list programming port. Assumes 32-bit registers.
package gcl_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned NUM_PAR  = 6;
    localparam int unsigned IDX_LSB  = 8;
    localparam int unsigned SEL_BIT  = 2;
    localparam int unsigned GO_BIT   = 0;
    localparam int unsigned OFF_LSB  = 23;
    localparam int unsigned OFF_W    = 9;
    localparam logic [15:0] OFS_MAIN = 16'h1050;
    localparam logic [15:0] OFS_CTRL = 16'h1080;
    localparam logic [15:0] OFS_DATA = 16'h1084;

    // Order of the parameter set; software relies on these index values.
    typedef enum logic [2:0] {
        PAR_BASE_LO = 3'd0,
        PAR_BASE_HI = 3'd1,
        PAR_CYC_LO  = 3'd2,
        PAR_CYC_HI  = 3'd3,
        PAR_EXT     = 3'd4,
        PAR_LEN     = 3'd5
    } par_idx_e;
endpackage

// File: rtl/gcl_stage_port.sv
// Staging data/control pair with a self-clearing start bit.
// A start write arms a counter of LAT cycles. When it expires, the module
// emits a one-cycle commit pulse carrying the staged index, select and data.
// Assumes LAT >= 1. Writes to either register are dropped while busy.
module gcl_stage_port
    import gcl_pkg::*;
#(
    parameter int unsigned LAT   = 2,
    parameter int unsigned IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              wr_ctrl,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] data_q,
    output logic [WORD_W-1:0] ctrl_rd,
    output logic              start_o,
    output logic              commit_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              sel_o
);
    localparam int unsigned CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             sel_q;
    logic             start_q;

    // Staging data register: accepts a value only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   data_q <= '0;
        else if (wr_data && !start_q) data_q <= wdata;
    end

    // Staging control register and commit countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            sel_q   <= 1'b0;
            start_q <= 1'b0;
            cnt_q   <= '0;
        end else if (start_q) begin
            if (cnt_q == CNT_W'(1)) begin
                start_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end else if (wr_ctrl) begin
            idx_q   <= wdata[IDX_LSB +: IDX_W];
            sel_q   <= wdata[SEL_BIT];
            start_q <= wdata[GO_BIT];
            cnt_q   <= wdata[GO_BIT] ? CNT_W'(LAT) : '0;
        end
    end

    // Commit pulse in the last busy cycle.
    always_comb commit_o = start_q && (cnt_q == CNT_W'(1));

    // Readback image of the control register.
    always_comb begin
        ctrl_rd                      = '0;
        ctrl_rd[IDX_LSB +: IDX_W]    = idx_q;
        ctrl_rd[SEL_BIT]             = sel_q;
        ctrl_rd[GO_BIT]              = start_q;
    end

    assign start_o = start_q;
    assign idx_o   = idx_q;
    assign sel_o   = sel_q;
endmodule

// File: rtl/gcl_sched_ctrl.sv
// Scheduler control register: enable, switch request and time offset.
// A pending request yields a one-cycle swap pulse, and the request clears on
// the following edge; a write of the request bit on that edge is dropped.
module gcl_sched_ctrl
    import gcl_pkg::*;
#(
    parameter int unsigned OW = OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          wr_en_bit,
    input  logic          wr_sw_bit,
    input  logic [OW-1:0] wr_off,
    output logic          en_o,
    output logic          sw_o,
    output logic [OW-1:0] off_o,
    output logic          swap_o
);
    logic swapped_q;

    // Enable and offset fields: plain write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= 1'b0;
            off_o <= '0;
        end else if (wr) begin
            en_o  <= wr_en_bit;
            off_o <= wr_off;
        end
    end

    // Switch request with its self-clearing sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_o      <= 1'b0;
            swapped_q <= 1'b0;
        end else if (swapped_q) begin
            sw_o      <= 1'b0;
            swapped_q <= 1'b0;
        end else begin
            if (sw_o) swapped_q <= 1'b1;
            if (wr)   sw_o      <= wr_sw_bit;
        end
    end

    // Exchange the banks exactly once per request.
    always_comb swap_o = sw_o && !swapped_q;
endmodule

// File: rtl/gcl_bank_store.sv
// Two banks of parameters and list entries. One bank is active and drives the
// outputs; the other is the shadow. Commits go to the shadow while enabled
// and to the active bank otherwise. Out-of-range indices are discarded.
module gcl_bank_store
    import gcl_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned IDX_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic                    sel_par,
    input  logic [IDX_W-1:0]        idx,
    input  logic [WORD_W-1:0]       data,
    input  logic                    en,
    input  logic                    swap,
    output logic [2*WORD_W-1:0]     base_time_o,
    output logic [2*WORD_W-1:0]     cycle_time_o,
    output logic [WORD_W-1:0]       time_ext_o,
    output logic [WORD_W-1:0]       list_len_o,
    output logic [DEPTH*WORD_W-1:0] gate_list_o
);
    localparam int unsigned BANKS = 2;

    logic [WORD_W-1:0] par_q [BANKS][NUM_PAR];
    logic [WORD_W-1:0] lst_q [BANKS][DEPTH];
    logic              act_q;
    logic              tgt;
    logic              par_hit;
    logic              lst_hit;

    // Destination bank and range checks for the pending commit.
    always_comb begin
        tgt     = en ? ~act_q : act_q;
        par_hit = commit &&  sel_par && (int'(idx) < int'(NUM_PAR));
        lst_hit = commit && !sel_par && (int'(idx) < int'(DEPTH));
    end

    // Active-bank pointer, toggled by a swap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= 1'b0;
        else if (swap) act_q <= ~act_q;
    end

    // Parameter storage for both banks.
    always_ff @(posedge clk) begin
        for (int b = 0; b < int'(BANKS); b++) begin
            for (int p = 0; p < int'(NUM_PAR); p++) begin
                if (!rst_n)
                    par_q[b][p] <= '0;
                else if (par_hit && int'(tgt) == b && int'(idx) == p)
                    par_q[b][p] <= data;
            end
        end
    end

    // List storage for both banks.
    always_ff @(posedge clk) begin
        for (int b = 0; b < int'(BANKS); b++) begin
            for (int e = 0; e < int'(DEPTH); e++) begin
                if (!rst_n)
                    lst_q[b][e] <= '0;
                else if (lst_hit && int'(tgt) == b && int'(idx) == e)
                    lst_q[b][e] <= data;
            end
        end
    end

    // Active parameter view.
    always_comb begin
        base_time_o  = {par_q[act_q][PAR_BASE_HI], par_q[act_q][PAR_BASE_LO]};
        cycle_time_o = {par_q[act_q][PAR_CYC_HI],  par_q[act_q][PAR_CYC_LO]};
        time_ext_o   = par_q[act_q][PAR_EXT];
        list_len_o   = par_q[act_q][PAR_LEN];
    end

    // Active list view, one word per entry.
    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_list_out
        assign gate_list_o[g*WORD_W +: WORD_W] = lst_q[act_q][g];
    end
endmodule

// File: rtl/gcl_prog_port.sv
// Top: register decode, registered read mux, and the three submodules.
// Assumes one access per cycle at most; reads have one cycle of latency.
module gcl_prog_port
    import gcl_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned LAT     = 2,
    parameter int unsigned BUS_AW  = 16,
    localparam int unsigned LIST_W = DEPTH * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 sched_en_o,
    output logic [OFF_W-1:0]     time_offset_o,
    output logic [2*WORD_W-1:0]  base_time_o,
    output logic [2*WORD_W-1:0]  cycle_time_o,
    output logic [WORD_W-1:0]    time_ext_o,
    output logic [WORD_W-1:0]    list_len_o,
    output logic [LIST_W-1:0]    gate_list_o
);
    logic              hit_main, hit_ctrl, hit_data;
    logic [WORD_W-1:0] data_q, ctrl_rd, main_rd;
    logic              start_flag, commit_go, swap_go, sw_req;
    logic [IDX_W-1:0]  c_idx;
    logic              c_sel;

    // Address decode.
    always_comb begin
        hit_main = (bus_addr == BUS_AW'(OFS_MAIN));
        hit_ctrl = (bus_addr == BUS_AW'(OFS_CTRL));
        hit_data = (bus_addr == BUS_AW'(OFS_DATA));
    end

    gcl_stage_port #(.LAT(LAT), .IDX_W(IDX_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (bus_wr && hit_data),
        .wr_ctrl  (bus_wr && hit_ctrl),
        .wdata    (bus_wdata),
        .data_q   (data_q),
        .ctrl_rd  (ctrl_rd),
        .start_o  (start_flag),
        .commit_o (commit_go),
        .idx_o    (c_idx),
        .sel_o    (c_sel)
    );

    gcl_sched_ctrl #(.OW(OFF_W)) u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr && hit_main),
        .wr_en_bit (bus_wdata[0]),
        .wr_sw_bit (bus_wdata[1]),
        .wr_off    (bus_wdata[OFF_LSB +: OFF_W]),
        .en_o      (sched_en_o),
        .sw_o      (sw_req),
        .off_o     (time_offset_o),
        .swap_o    (swap_go)
    );

    gcl_bank_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit_go),
        .sel_par      (c_sel),
        .idx          (c_idx),
        .data         (data_q),
        .en           (sched_en_o),
        .swap         (swap_go),
        .base_time_o  (base_time_o),
        .cycle_time_o (cycle_time_o),
        .time_ext_o   (time_ext_o),
        .list_len_o   (list_len_o),
        .gate_list_o  (gate_list_o)
    );

    // Readback image of the scheduler control register.
    always_comb begin
        main_rd                    = '0;
        main_rd[0]                 = sched_en_o;
        main_rd[1]                 = sw_req;
        main_rd[OFF_LSB +: OFF_W]  = time_offset_o;
    end

    // Registered read mux, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) begin
            if (hit_data)      bus_rdata <= data_q;
            else if (hit_ctrl) bus_rdata <= ctrl_rd;
            else if (hit_main) bus_rdata <= main_rd;
            else               bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/gcl_prog_port_chk.sv
// Checker for gcl_prog_port: handshake timing, busy protection, switch
// sequencing and stability of the active view. Bound to the top below.
module gcl_prog_port_chk #(
    parameter int unsigned LIST_W = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_flag,
    input logic              commit_go,
    input logic              swap_go,
    input logic              sw_req,
    input logic              sched_en_o,
    input logic [31:0]       data_q,
    input logic [63:0]       base_time_o,
    input logic [31:0]       list_len_o,
    input logic [LIST_W-1:0] gate_list_o
);
    // R3: start stays high for two cycles, then drops.
    assert_start_two_cycles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag) |=> start_flag ##1 !start_flag);

    // R3: the start bit only falls after a commit cycle.
    assert_commit_before_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_flag) |-> $past(commit_go));

    // R5: staged data is frozen while busy.
    assert_data_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_flag |=> $stable(data_q));

    // R10: one swap per request, request gone two edges later.
    assert_switch_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_go |=> (!swap_go && sw_req) ##1 !sw_req);

    // R9 / R11: the active view moves only on a swap or a disabled-mode commit.
    assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_go && !(commit_go && !sched_en_o)) |=>
        ($stable(base_time_o) && $stable(list_len_o) && $stable(gate_list_o)));
endmodule

bind gcl_prog_port gcl_prog_port_chk #(.LIST_W(LIST_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_flag  (start_flag),
    .commit_go   (commit_go),
    .swap_go     (swap_go),
    .sw_req      (sw_req),
    .sched_en_o  (sched_en_o),
    .data_q      (data_q),
    .base_time_o (base_time_o),
    .list_len_o  (list_len_o),
    .gate_list_o (gate_list_o)
);

// File: tb/sim_gcl_prog_port.sv
module sim_gcl_prog_port;
    localparam int DEPTH = 16;
    localparam logic [15:0] A_MAIN = 16'h1050;
    localparam logic [15:0] A_CTRL = 16'h1080;
    localparam logic [15:0] A_DATA = 16'h1084;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic sched_en_o;
    logic [8:0] time_offset_o;
    logic [63:0] base_time_o, cycle_time_o;
    logic [31:0] time_ext_o, list_len_o;
    logic [DEPTH*32-1:0] gate_list_o;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gcl_prog_port u0 (.*);

    // Behavioural reference model
    logic [31:0] m_data, m_rd;
    logic [7:0]  m_idx;
    bit m_sel, m_start, m_en, m_sw, m_swdone;
    int m_cnt, m_bank;
    logic [8:0]  m_off;
    logic [31:0] m_par [2][6];
    logic [31:0] m_lst [2][DEPTH];

    function automatic logic [31:0] m_read(logic [15:0] a);
        if (a == A_DATA) return m_data;
        if (a == A_CTRL) return {16'h0, m_idx, 5'h0, m_sel, 1'b0, m_start};
        if (a == A_MAIN) return {m_off, 21'h0, m_sw, m_en};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = 0; m_rd = 0; m_idx = 0; m_sel = 0; m_start = 0; m_cnt = 0;
            m_en = 0; m_sw = 0; m_swdone = 0; m_bank = 0; m_off = 0;
            for (int b = 0; b < 2; b++) begin
                for (int p = 0; p < 6; p++) m_par[b][p] = 0;
                for (int e = 0; e < DEPTH; e++) m_lst[b][e] = 0;
            end
        end else begin
            automatic bit busy_old = m_start;
            automatic bit en_old = m_en;
            automatic int bank_old = m_bank;
            automatic int tgt = en_old ? 1 - bank_old : bank_old;
            if (bus_rd) m_rd = m_read(bus_addr);
            if (bus_wr && bus_addr == A_DATA && !busy_old) m_data = bus_wdata;
            if (busy_old) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_start = 0;
                    if (m_sel && m_idx < 6) m_par[tgt][m_idx] = m_data;
                    if (!m_sel && m_idx < DEPTH) m_lst[tgt][m_idx] = m_data;
                end
            end else if (bus_wr && bus_addr == A_CTRL) begin
                m_idx = bus_wdata[15:8]; m_sel = bus_wdata[2];
                m_start = bus_wdata[0]; m_cnt = 2;
            end
            if (m_swdone) begin
                m_sw = 0; m_swdone = 0;
            end else begin
                if (m_sw) begin m_bank = 1 - m_bank; m_swdone = 1; end
                if (bus_wr && bus_addr == A_MAIN) m_sw = bus_wdata[1];
            end
            if (bus_wr && bus_addr == A_MAIN) begin
                m_en = bus_wdata[0]; m_off = bus_wdata[31:23];
            end
        end
    end

    task automatic tally(bit ok, string req, string what, logic [DEPTH*32-1:0] act, logic [DEPTH*32-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [DEPTH*32-1:0] el;
            for (int e = 0; e < DEPTH; e++) el[e*32 +: 32] = m_lst[m_bank][e];
            tally(bus_rdata === m_rd, "R2", "rdata", bus_rdata, m_rd);
            tally(base_time_o === {m_par[m_bank][1], m_par[m_bank][0]}, "R6/R9/R11", "base",
                  base_time_o, {m_par[m_bank][1], m_par[m_bank][0]});
            tally(cycle_time_o === {m_par[m_bank][3], m_par[m_bank][2]}, "R6", "cycle",
                  cycle_time_o, {m_par[m_bank][3], m_par[m_bank][2]});
            tally(time_ext_o === m_par[m_bank][4], "R6", "ext", time_ext_o, m_par[m_bank][4]);
            tally(list_len_o === m_par[m_bank][5], "R6/R10", "len", list_len_o, m_par[m_bank][5]);
            tally(gate_list_o === el, "R7/R9/R10", "list", gate_list_o, el);
            tally({sched_en_o, time_offset_o} === {m_en, m_off}, "R8", "main", {sched_en_o, time_offset_o}, {m_en, m_off});
        end
    end

    task automatic bus_write(logic [15:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(logic [15:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 0; d = bus_rdata;
    endtask

    task automatic prog(bit sel, logic [7:0] idx, logic [31:0] d);
        logic [31:0] r;
        bus_write(A_DATA, d);
        bus_write(A_CTRL, {16'h0, idx, 5'h0, sel, 2'b00});
        bus_write(A_CTRL, {16'h0, idx, 5'h0, sel, 2'b01});
        for (int i = 0; i < 10; i++) begin
            bus_read(A_CTRL, r);
            if (r[0] == 1'b0) break;
        end
        tally(r[0] == 1'b0, "R3", "start not cleared", r, 0);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [DEPTH*32-1:0] snap;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        tally(bus_rdata == 0 && list_len_o == 0 && gate_list_o == 0 && base_time_o == 0
              && !sched_en_o, "R1", "reset", {base_time_o, list_len_o}, 0);

        // R6, R7, R11: disabled-mode programming goes straight to outputs
        prog(1, 0, 32'h1111_0000);
        prog(1, 1, 32'h0000_0022);
        prog(1, 2, 32'h0001_0000);
        prog(1, 4, 32'h0000_0040);
        prog(1, 5, 32'd4);
        for (int e = 0; e < 4; e++) prog(0, 8'(e), 32'hA0 + 32'(e));
        tally(base_time_o == 64'h0000_0022_1111_0000, "R6", "base time", base_time_o, 64'h0000_0022_1111_0000);
        tally(list_len_o == 4, "R11", "length direct", list_len_o, 4);
        tally(gate_list_o[3*32 +: 32] == 32'hA3, "R7", "entry 3", gate_list_o[3*32 +: 32], 32'hA3);

        // R3: start reads 1 for two cycles, then 0
        bus_write(A_DATA, 32'hB7);
        bus_write(A_CTRL, 32'h0000_0701);
        bus_read(A_CTRL, r); tally(r == 32'h0000_0701, "R3", "busy cycle 1", r, 32'h701);
        bus_read(A_CTRL, r); tally(r == 32'h0000_0701, "R3", "busy cycle 2", r, 32'h701);
        bus_read(A_CTRL, r); tally(r == 32'h0000_0700, "R3", "cleared", r, 32'h700);
        tally(gate_list_o[7*32 +: 32] == 32'hB7, "R3", "entry 7 stored", gate_list_o[7*32 +: 32], 32'hB7);

        // R5: writes during busy are dropped
        bus_write(A_DATA, 32'hC1);
        bus_write(A_CTRL, 32'h0000_0801);
        bus_write(A_DATA, 32'hEE);
        bus_write(A_CTRL, 32'h0000_0905);
        bus_read(A_DATA, r); tally(r == 32'hC1, "R5", "data kept", r, 32'hC1);
        bus_read(A_CTRL, r); tally(r == 32'h0000_0800, "R5", "ctrl kept", r, 32'h800);
        tally(gate_list_o[8*32 +: 32] == 32'hC1, "R5", "entry 8", gate_list_o[8*32 +: 32], 32'hC1);

        // R7 / R6: out-of-range indices discarded
        snap = gate_list_o;
        prog(0, 8'd20, 32'hDD);
        tally(gate_list_o == snap, "R7", "index 20 discarded", gate_list_o, snap);
        prog(1, 8'd7, 32'hDD);
        tally(list_len_o == 4 && time_ext_o == 32'h40, "R6", "index 7 discarded", list_len_o, 4);

        // R4: control write without start commits nothing
        bus_write(A_DATA, 32'hDEAD);
        bus_write(A_CTRL, 32'h0000_0000);
        repeat (4) @(negedge clk);
        tally(gate_list_o[31:0] == 32'hA0, "R4", "entry 0 untouched", gate_list_o[31:0], 32'hA0);
        bus_read(A_CTRL, r); tally(r == 32'h0, "R4", "ctrl fields", r, 0);

        // R2: readback and unmapped offset
        bus_read(A_DATA, r); tally(r == 32'hDEAD, "R2", "data readback", r, 32'hDEAD);
        bus_read(16'h0000, r); tally(r == 32'h0, "R2", "unmapped", r, 0);

        // R8: enable and offset
        bus_write(A_MAIN, (32'h155 << 23) | 32'h1);
        tally(sched_en_o && time_offset_o == 9'h155, "R8", "enable/offset", {sched_en_o, time_offset_o}, {1'b1, 9'h155});
        bus_read(A_MAIN, r); tally(r == ((32'h155 << 23) | 32'h1), "R8", "main readback", r, (32'h155 << 23) | 1);

        // R9: enabled commits go to the shadow bank
        prog(0, 0, 32'h5555);
        prog(1, 5, 32'd2);
        tally(list_len_o == 4 && gate_list_o[31:0] == 32'hA0, "R9", "active unchanged", list_len_o, 4);

        // R10: switch request exchanges banks and clears itself
        bus_write(A_MAIN, (32'h155 << 23) | 32'h3);
        bus_read(A_MAIN, r); tally(r[1] == 1'b1, "R10", "request pending", r, (32'h155 << 23) | 3);
        tally(list_len_o == 2 && gate_list_o[31:0] == 32'h5555 && base_time_o == 0, "R10", "banks swapped",
              list_len_o, 2);
        bus_read(A_MAIN, r); tally(r[1] == 1'b1, "R10", "request second cycle", r, (32'h155 << 23) | 3);
        bus_read(A_MAIN, r); tally(r[1] == 1'b0, "R10", "request cleared", r, (32'h155 << 23) | 1);

        // R11: disabled again, commit lands in active bank
        bus_write(A_MAIN, 32'h0);
        prog(1, 5, 32'd9);
        tally(list_len_o == 9, "R11", "direct after disable", list_len_o, 9);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule